// File: doc/BRIEF.md
# Display Status Register with Interrupt

This block gives the CPU a window onto the state of the display timing. A status byte combines two kinds of bits. The live bits show the current display phase and whether the current line number matches a software-chosen value. The stored bits let software choose which display conditions raise an interrupt. A second byte holds that line-compare value. Both bytes sit on a simple synchronous register bus. Reads are combinational. Writes land on the clock edge while the write strobe is high.

The timing sequencer supplies the current phase code and the current line number. The block compares the line number with the stored compare value. It then forms one internal request line: the OR of every enabled phase condition and the enabled line-match condition. A one-cycle interrupt pulse is issued only when that line goes from low to high. If the line stays high across a change of phase, no second pulse is issued.

Top module: `disp_stat`

## Requirements
- R1: Reading the status address (default 0xFF41) returns the live phase code in bits 1:0 (00 horizontal blank, 01 vertical blank, 10 object search, 11 pixel transfer). CPU writes to these bits are ignored.
- R2: Status bit 2 reads 1 exactly when the line input equals the stored compare value, and 0 otherwise. It is not writable.
- R3: A write to the status address stores bits 6:3 only, and these read back unchanged. Bit 7 always reads 0.
- R4: The compare address (default 0xFF45) holds a fully readable and writable 8-bit value.
- R5: After reset, status bits 6:3 and the compare value are 0, and the interrupt output is low.
- R6: With bit 3 set, phase 00 is an interrupt source.
- R7: With bit 4 set, phase 01 is an interrupt source. With bit 5 set, phase 10 is an interrupt source. Phase 11 is never a source.
- R8: With bit 6 set, a line match (R2) is an interrupt source.
- R9: The interrupt output is high for one cycle only, on a rising edge of the OR of all enabled sources. A source that becomes active while the OR is already high produces no new pulse.
- R10: Reads of any other address return 0, and writes to any other address change no state.
- R11: The pulse appears in the cycle after the clock edge that first sees the OR high, and not on that edge itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wdata | input | 8 | Register bus write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Combinational read data |
| lcd_mode | input | 2 | Current display phase code |
| lcd_line | input | 8 | Current line number |
| stat_irq | output | 1 | One-cycle status interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit address and the two register addresses at 0xFF41 and 0xFF45. With the full 16-bit decode, the bench can probe the neighbouring address 0xFF42 and confirm that its reads return zero and its writes leave both registers untouched. The 8-bit line width lets the bench use line numbers from the vertical-blank range next to the compare value. The bench then switches the phase while the request line is held high, to show that no new pulse is issued, and drops the line to show that the edge detector re-arms.

// File: rtl/disp_stat_pkg.sv
package disp_stat_pkg;

    localparam int DATA_W     = 8;
    localparam int ENB_LO     = 3;
    localparam int ENB_HI     = 6;
    localparam int ENB_W      = ENB_HI - ENB_LO + 1;
    localparam int N_MODE_SRC = 3;            // phases 0..2 may raise a request
    localparam int ENB_MATCH  = N_MODE_SRC;   // enable slot for line match
    localparam int FLAG_BIT   = 2;

    typedef enum logic [1:0] {
        PH_HBLANK  = 2'b00,
        PH_VBLANK  = 2'b01,
        PH_OBJSCAN = 2'b10,
        PH_DRAW    = 2'b11
    } lcd_phase_e;

    typedef struct packed {
        logic [ENB_W-1:0]  enb;
        logic [DATA_W-1:0] cmp;
    } cfg_t;

    typedef struct packed {
        logic line;
        logic pulse;
    } edge_t;

endpackage

// File: rtl/dstat_cfg.sv
module dstat_cfg
    import disp_stat_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFF41,
    parameter logic [ADDR_W-1:0] CMP_ADDR  = 16'hFF45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output cfg_t              cfg_o
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (bus_we && bus_addr == STAT_ADDR) begin
            cfg_d.enb = bus_wdata[ENB_HI:ENB_LO];
        end
        if (bus_we && bus_addr == CMP_ADDR) begin
            cfg_d.cmp = bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/dstat_src.sv
module dstat_src
    import disp_stat_pkg::*;
(
    input  logic [1:0]        phase_i,
    input  logic [DATA_W-1:0] line_i,
    input  cfg_t              cfg_i,
    output logic              match_o,
    output logic              req_o
);

    logic [N_MODE_SRC-1:0] phase_hit;

    for (genvar g = 0; g < N_MODE_SRC; g++) begin : g_phase_src
        assign phase_hit[g] = cfg_i.enb[g] && (phase_i == 2'(g));
    end

    assign match_o = (line_i == cfg_i.cmp);
    assign req_o   = (|phase_hit) | (cfg_i.enb[ENB_MATCH] & match_o);

endmodule

// File: rtl/dstat_edge.sv
module dstat_edge
    import disp_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic pulse_o
);

    edge_t st_d, st_q;

    always_comb begin
        st_d.line  = req_i;
        st_d.pulse = req_i & ~st_q.line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

endmodule

// File: rtl/disp_stat.sv
module disp_stat
    import disp_stat_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFF41,
    parameter logic [ADDR_W-1:0] CMP_ADDR  = 16'hFF45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    input  logic [1:0]        lcd_mode,
    input  logic [7:0]        lcd_line,
    output logic              stat_irq
);

    cfg_t cfg_q;
    logic match_w;
    logic req_w;

    dstat_cfg #(
        .ADDR_W   (ADDR_W),
        .STAT_ADDR(STAT_ADDR),
        .CMP_ADDR (CMP_ADDR)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .cfg_o    (cfg_q)
    );

    dstat_src src_i (
        .phase_i(lcd_mode),
        .line_i (lcd_line),
        .cfg_i  (cfg_q),
        .match_o(match_w),
        .req_o  (req_w)
    );

    dstat_edge edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_w),
        .pulse_o(stat_irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STAT_ADDR) begin
            bus_rdata[1:0]           = lcd_mode;
            bus_rdata[FLAG_BIT]      = match_w;
            bus_rdata[ENB_HI:ENB_LO] = cfg_q.enb;
        end else if (bus_addr == CMP_ADDR) begin
            bus_rdata = cfg_q.cmp;
        end
    end

endmodule

// File: rtl/disp_stat_chk.sv
module disp_stat_chk
    import disp_stat_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFF41,
    parameter logic [ADDR_W-1:0] CMP_ADDR  = 16'hFF45
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_we,
    input logic [7:0]        bus_rdata,
    input logic [1:0]        lcd_mode,
    input logic              stat_irq,
    input cfg_t              cfg
);

    // R1
    mode_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == STAT_ADDR) |-> (bus_rdata[1:0] == lcd_mode));

    // R3
    top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == STAT_ADDR) |-> (bus_rdata[7] == 1'b0));

    // R3
    enb_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == STAT_ADDR) |=> (cfg.enb == $past(bus_wdata[ENB_HI:ENB_LO])));

    // R4
    cmp_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == CMP_ADDR) |=> (cfg.cmp == $past(bus_wdata)));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_irq |=> !stat_irq);

    // R10
    other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != STAT_ADDR && bus_addr != CMP_ADDR) |-> (bus_rdata == 8'h00));

endmodule

bind disp_stat disp_stat_chk #(
    .ADDR_W   (ADDR_W),
    .STAT_ADDR(STAT_ADDR),
    .CMP_ADDR (CMP_ADDR)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_we   (bus_we),
    .bus_rdata(bus_rdata),
    .lcd_mode (lcd_mode),
    .stat_irq (stat_irq),
    .cfg      (cfg_q)
);

// File: tb/disp_stat_tb_top.sv
module disp_stat_tb_top;

    localparam logic [15:0] A_STAT  = 16'hFF41;
    localparam logic [15:0] A_CMP   = 16'hFF45;
    localparam logic [15:0] A_OTHER = 16'hFF42;
    localparam int          NVEC    = 10;

    typedef struct packed {
        logic [7:0] en;
        logic [7:0] cmp;
        logic [1:0] mode;
        logic [7:0] ly;
        logic [7:0] stat;
        logic       irq;
    } vec_t;

    // write value, compare, phase, line, expected status, expected pulse
    localparam vec_t VEC [NVEC] = '{
        '{8'h8F, 8'd10, 2'd0, 8'd5,   8'h08, 1'b1},  // R6 R1
        '{8'h08, 8'd10, 2'd1, 8'd5,   8'h09, 1'b0},  // R6
        '{8'h10, 8'd0,  2'd1, 8'd150, 8'h11, 1'b1},  // R7
        '{8'h20, 8'd0,  2'd2, 8'd3,   8'h22, 1'b1},  // R7
        '{8'h20, 8'd0,  2'd3, 8'd3,   8'h23, 1'b0},  // R7
        '{8'h40, 8'd44, 2'd3, 8'd44,  8'h47, 1'b1},  // R8 R2
        '{8'h40, 8'd44, 2'd3, 8'd45,  8'h43, 1'b0},  // R8
        '{8'h00, 8'd7,  2'd2, 8'd7,   8'h06, 1'b0},  // R2
        '{8'hFF, 8'd99, 2'd3, 8'd98,  8'h7B, 1'b0},  // R3
        '{8'hFF, 8'd99, 2'd0, 8'd99,  8'h7C, 1'b1}   // R3 R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = A_STAT;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic [1:0]  lcd_mode = 2'd2;
    logic [7:0]  lcd_line = 8'd0;
    logic        stat_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    disp_stat dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_we   (bus_we),
        .bus_rdata(bus_rdata),
        .lcd_mode (lcd_mode),
        .lcd_line (lcd_line),
        .stat_irq (stat_irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input string req, input logic [15:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state; compare resets to 0 and line is 0, so flag is set (R2)
        rd("R5", A_STAT, 8'h06);
        rd("R5", A_CMP, 8'h00);
        chk("R5", {7'd0, stat_irq}, 8'h00);

        // R4 compare read/write
        wr(A_CMP, 8'hA5);
        rd("R4", A_CMP, 8'hA5);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            wr(A_STAT, 8'h00);
            wr(A_CMP, VEC[i].cmp);
            lcd_mode = VEC[i].mode;
            lcd_line = VEC[i].ly;
            wr(A_STAT, VEC[i].en);
            rd("R1 R2 R3 status", A_STAT, VEC[i].stat);
            chk("R11 no pulse on sampling edge", {7'd0, stat_irq}, 8'h00);
            @(negedge clk);
            chk("R6 R7 R8 pulse", {7'd0, stat_irq}, {7'd0, VEC[i].irq});
            @(negedge clk);
            chk("R9 pulse width", {7'd0, stat_irq}, 8'h00);
        end

        // R9: a phase change while the request stays high gives no new pulse
        wr(A_STAT, 8'h00);
        lcd_mode = 2'd0;
        lcd_line = 8'd1;
        wr(A_STAT, 8'h18);
        @(negedge clk);
        chk("R9 first pulse", {7'd0, stat_irq}, 8'h01);
        @(negedge clk);
        chk("R9 pulse ends", {7'd0, stat_irq}, 8'h00);
        lcd_mode = 2'd1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R9 held high no re-pulse", {7'd0, stat_irq}, 8'h00);
        end
        lcd_mode = 2'd2;
        @(negedge clk);
        chk("R9 line low", {7'd0, stat_irq}, 8'h00);
        lcd_mode = 2'd0;
        @(negedge clk);
        chk("R9 re-armed pulse", {7'd0, stat_irq}, 8'h01);

        // R10 other address
        wr(A_OTHER, 8'hFF);
        rd("R10 status kept", A_STAT, 8'h18);
        rd("R10 compare kept", A_CMP, 8'd99);
        rd("R10 read zero", A_OTHER, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule